// File: doc/BRIEF.md
# Memory channel index hash unit

This block turns an address that has already been split into a channel field, a row field and a bank field into the final memory channel number. A two-bit mode input picks how the channel is formed. In the straight mode the channel field is used unchanged. In the row-XOR mode the low row bits are XORed into the channel, which spreads consecutive rows across channels. In the entropy mode each of the five channel bits is folded together with a fixed set of row and bank bits, so that page and bank address bits steer channel choice.

The result goes through one register stage with a valid flag. When the hashed channel is not below the configured channel count, a range error flag is raised with the result. The reserved mode value passes the channel through and raises a mode error flag.

Top module: `chx_hash`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid`, `out_range_err` and `out_mode_err` are 0 after that edge.
- R2: `out_valid` at any edge equals `in_valid` from the edge before (one register stage).
- R3: With `in_mode` = 0 (straight), `out_chan` equals `in_chan` of the accepted input.
- R4: With `in_mode` = 1 (row XOR), `out_chan` = `in_chan` XOR (`in_row` AND (NUM_CHAN-1)); NUM_CHAN is a power of two, so an in-range channel stays in range.
- R5: With `in_mode` = 2 (entropy), output bit k is `in_chan[k]` XORed with these taps: bit 0 row {0,5,9,10,13} bank {0,3}; bit 1 row {1,6,11,12} bank {1,2,3}; bit 2 row {2,7,8,9,14} bank {1}; bit 3 row {3,8,10,11} bank {2,3}; bit 4 row {4,5,8,9,12} bank {0,1}.
- R6: With `in_mode` = 3 (reserved), `out_chan` equals `in_chan` and `out_mode_err` is 1; in modes 0 to 2 `out_mode_err` is 0.
- R7: `out_range_err` is 1 with a valid result exactly when `out_chan` >= NUM_CHAN (default 16).
- R8: When `out_valid` is 0, `out_range_err` and `out_mode_err` are 0.
- R9: While `in_valid` is 0, `out_chan` keeps the last valid result whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input fields are valid this cycle |
| in_mode | input | 2 | 0 straight, 1 row XOR, 2 entropy, 3 reserved |
| in_chan | input | CHAN_W | Raw channel field |
| in_row | input | ROW_W | Row field |
| in_bank | input | BANK_W | Bank field |
| out_valid | output | 1 | Result valid |
| out_chan | output | CHAN_W | Hashed channel |
| out_range_err | output | 1 | Result not below NUM_CHAN |
| out_mode_err | output | 1 | Reserved mode was used |

## Verification
Every result is due exactly one rising edge after its input is presented, so the bench drives inputs on the falling edge and the monitor compares the outputs on the following falling edge, half a period after the capturing edge. Each driven input pushes its expected channel and flags into a queue at the moment it is applied, and the monitor pops one entry for every cycle with `out_valid` high, so a missing, extra or late result shows up as a mismatch or a leftover entry. Idle cycles with junk on the data inputs check that the held channel and cleared flags stay put.

// File: rtl/chx_pkg.sv
// Shared definitions for the channel index hash unit.
// Assumes: the mode field is two bits wide; the entropy hash works on
// fixed field widths listed below.
package chx_pkg;

    // Channel forming mode carried on in_mode.
    typedef enum logic [1:0] {
        MODE_STRAIGHT = 2'd0,
        MODE_ROW_XOR  = 2'd1,
        MODE_ENTROPY  = 2'd2,
        MODE_RESERVED = 2'd3
    } chx_mode_e;

    // Field widths that the entropy taps reach.
    localparam int unsigned ENT_CHAN_BITS = 5;
    localparam int unsigned ENT_ROW_BITS  = 15;
    localparam int unsigned ENT_BANK_BITS = 4;

endpackage

// File: rtl/chx_perm.sv
// Row-XOR permutation: folds the low row bits into the channel.
// Assumes: NUM_CHAN is a power of two no larger than 2**CHAN_W, and the
// caller passes the low CHAN_W row bits.
module chx_perm #(
    parameter int unsigned CHAN_W   = 5,
    parameter int unsigned NUM_CHAN = 16
) (
    input  logic [CHAN_W-1:0] chan_i,
    input  logic [CHAN_W-1:0] row_lo_i,
    output logic [CHAN_W-1:0] chan_o
);
    localparam logic [CHAN_W:0] MASK_WIDE = (CHAN_W+1)'(NUM_CHAN - 1);
    localparam logic [CHAN_W-1:0] ROW_MASK = MASK_WIDE[CHAN_W-1:0];

    // Combine channel with the masked row bits.
    always_comb begin
        chan_o = chan_i ^ (row_lo_i & ROW_MASK);
    end
endmodule

// File: rtl/chx_entropy.sv
// Entropy hash: each of the low five channel bits is XORed with a fixed
// set of row and bank bits. Channel bits above the fifth pass through.
// Assumes: missing row or bank bits (narrow fields) read as zero.
module chx_entropy
    import chx_pkg::*;
#(
    parameter int unsigned CHAN_W = 5,
    parameter int unsigned ROW_W  = 15,
    parameter int unsigned BANK_W = 4
) (
    input  logic [CHAN_W-1:0] chan_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic [CHAN_W-1:0] chan_o
);
    logic [ENT_ROW_BITS-1:0]  r;
    logic [ENT_BANK_BITS-1:0] b;
    logic [ENT_CHAN_BITS-1:0] c;
    logic [ENT_CHAN_BITS-1:0] h;

    // Zero-extend or pick the fields to the tap widths.
    for (genvar i = 0; i < ENT_ROW_BITS; i++) begin : g_row
        if (i < ROW_W) begin : g_have
            assign r[i] = row_i[i];
        end else begin : g_zero
            assign r[i] = 1'b0;
        end
    end
    for (genvar i = 0; i < ENT_BANK_BITS; i++) begin : g_bank
        if (i < BANK_W) begin : g_have
            assign b[i] = bank_i[i];
        end else begin : g_zero
            assign b[i] = 1'b0;
        end
    end
    for (genvar i = 0; i < ENT_CHAN_BITS; i++) begin : g_chan
        if (i < CHAN_W) begin : g_have
            assign c[i] = chan_i[i];
        end else begin : g_zero
            assign c[i] = 1'b0;
        end
    end

    // Tap network for the five hashed bits.
    always_comb begin
        h[0] = c[0] ^ r[0] ^ r[5] ^ r[9]  ^ r[10] ^ r[13] ^ b[0] ^ b[3];
        h[1] = c[1] ^ r[1] ^ r[6] ^ r[11] ^ r[12] ^ b[1] ^ b[2] ^ b[3];
        h[2] = c[2] ^ r[2] ^ r[7] ^ r[8]  ^ r[9]  ^ r[14] ^ b[1];
        h[3] = c[3] ^ r[3] ^ r[8] ^ r[10] ^ r[11] ^ b[2] ^ b[3];
        h[4] = c[4] ^ r[4] ^ r[5] ^ r[8]  ^ r[9]  ^ r[12] ^ b[0] ^ b[1];
    end

    // Map hashed bits back to the channel width.
    for (genvar i = 0; i < CHAN_W; i++) begin : g_out
        if (i < ENT_CHAN_BITS) begin : g_hash
            assign chan_o[i] = h[i];
        end else begin : g_pass
            assign chan_o[i] = chan_i[i];
        end
    end
endmodule

// File: rtl/chx_range.sv
// Range check: flags a channel number that is not below NUM_CHAN.
// Assumes: NUM_CHAN fits in 32 bits.
module chx_range #(
    parameter int unsigned CHAN_W   = 5,
    parameter int unsigned NUM_CHAN = 16
) (
    input  logic [CHAN_W-1:0] chan_i,
    output logic              bad_o
);
    // Compare at 32 bits so NUM_CHAN = 2**CHAN_W is representable.
    always_comb begin
        bad_o = (32'(chan_i) >= NUM_CHAN);
    end
endmodule

// File: rtl/chx_hash.sv
// Channel index hash unit top: selects the channel forming mode, checks
// the range and registers the result for one cycle.
// Assumes: NUM_CHAN is a power of two, ROW_W >= CHAN_W, synchronous
// active-low reset.
module chx_hash
    import chx_pkg::*;
#(
    parameter int unsigned CHAN_W   = 5,
    parameter int unsigned ROW_W    = 15,
    parameter int unsigned BANK_W   = 4,
    parameter int unsigned NUM_CHAN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_mode,
    input  logic [CHAN_W-1:0] in_chan,
    input  logic [ROW_W-1:0]  in_row,
    input  logic [BANK_W-1:0] in_bank,
    output logic              out_valid,
    output logic [CHAN_W-1:0] out_chan,
    output logic              out_range_err,
    output logic              out_mode_err
);
    logic [CHAN_W-1:0] perm_chan;
    logic [CHAN_W-1:0] ent_chan;
    logic [CHAN_W-1:0] sel_chan;
    logic              sel_mode_err;
    logic              sel_range_err;

    chx_perm #(.CHAN_W(CHAN_W), .NUM_CHAN(NUM_CHAN)) u_perm (
        .chan_i   (in_chan),
        .row_lo_i (in_row[CHAN_W-1:0]),
        .chan_o   (perm_chan)
    );

    chx_entropy #(.CHAN_W(CHAN_W), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_ent (
        .chan_i (in_chan),
        .row_i  (in_row),
        .bank_i (in_bank),
        .chan_o (ent_chan)
    );

    // Pick the channel for the requested mode.
    always_comb begin
        sel_mode_err = 1'b0;
        case (chx_mode_e'(in_mode))
            MODE_STRAIGHT: sel_chan = in_chan;
            MODE_ROW_XOR:  sel_chan = perm_chan;
            MODE_ENTROPY:  sel_chan = ent_chan;
            default: begin
                sel_chan     = in_chan;
                sel_mode_err = 1'b1;
            end
        endcase
    end

    chx_range #(.CHAN_W(CHAN_W), .NUM_CHAN(NUM_CHAN)) u_range (
        .chan_i (sel_chan),
        .bad_o  (sel_range_err)
    );

    // Output stage: valid and flags each cycle, channel only when accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_chan      <= '0;
            out_range_err <= 1'b0;
            out_mode_err  <= 1'b0;
        end else begin
            out_valid     <= in_valid;
            out_range_err <= in_valid & sel_range_err;
            out_mode_err  <= in_valid & sel_mode_err;
            if (in_valid) begin
                out_chan <= sel_chan;
            end
        end
    end

    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_straight_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'd0) |=> (out_chan == $past(in_chan)));
    assert_perm_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'd1 && 32'(in_chan) < NUM_CHAN) |=> !out_range_err);
    assert_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'd3) |=> (out_mode_err && out_chan == $past(in_chan)));
    assert_flags_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_range_err && !out_mode_err));
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_chan));
endmodule

// File: tb/chx_hash_tb.sv
module chx_hash_tb;
    localparam int CW = 5;
    localparam int RW = 15;
    localparam int BW = 4;
    localparam int NC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_mode = 2'd0;
    logic [CW-1:0] in_chan = '0;
    logic [RW-1:0] in_row = '0;
    logic [BW-1:0] in_bank = '0;
    logic          out_valid;
    logic [CW-1:0] out_chan;
    logic          out_range_err;
    logic          out_mode_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    bit have_last = 1'b0;
    logic [CW-1:0] last_chan = '0;
    logic [CW+1:0] expq[$];

    always #2 clk = ~clk;

    chx_hash #(.CHAN_W(CW), .ROW_W(RW), .BANK_W(BW), .NUM_CHAN(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_chan(in_chan), .in_row(in_row), .in_bank(in_bank),
        .out_valid(out_valid), .out_chan(out_chan),
        .out_range_err(out_range_err), .out_mode_err(out_mode_err));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Independent model of the requirement text.
    function automatic logic [CW-1:0] model(input logic [1:0] m, input logic [CW-1:0] c,
                                            input logic [RW-1:0] r, input logic [BW-1:0] b);
        logic [CW-1:0] o;
        o = c;
        if (m == 2'd1) o = c ^ (r[CW-1:0] & CW'(NC - 1));
        if (m == 2'd2) begin
            o[0] = c[0] ^ (^(r & 15'h2621)) ^ (^(b & 4'h9));
            o[1] = c[1] ^ (^(r & 15'h1842)) ^ (^(b & 4'hE));
            o[2] = c[2] ^ (^(r & 15'h4384)) ^ (^(b & 4'h2));
            o[3] = c[3] ^ (^(r & 15'h0D08)) ^ (^(b & 4'hC));
            o[4] = c[4] ^ (^(r & 15'h1330)) ^ (^(b & 4'h3));
        end
        return o;
    endfunction

    task automatic drive(input logic [1:0] m, input logic [CW-1:0] c,
                         input logic [RW-1:0] r, input logic [BW-1:0] b);
        logic [CW-1:0] e;
        @(negedge clk);
        in_valid = 1'b1; in_mode = m; in_chan = c; in_row = r; in_bank = b;
        e = model(m, c, r, b);
        expq.push_back({(m == 2'd3), (32'(e) >= NC), e});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_mode = 2'(i); in_chan = CW'(7 * i + 3);
            in_row = RW'(16'h5A5A ^ 16'(i)); in_bank = BW'(i);
        end
    endtask

    // Monitor: compare one result per valid cycle half a period after the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R2 unexpected valid", 1, 0);
                end else begin
                    logic [CW+1:0] e;
                    e = expq.pop_front();
                    check(out_chan == e[CW-1:0], "R3/R4/R5/R6 channel", out_chan, e[CW-1:0]);
                    check(out_range_err == e[CW], "R7 range flag", out_range_err, e[CW]);
                    check(out_mode_err == e[CW+1], "R6 mode flag", out_mode_err, e[CW+1]);
                    last_chan = out_chan;
                    have_last = 1'b1;
                end
            end else begin
                check(!out_range_err && !out_mode_err, "R8 flags while idle",
                      {out_range_err, out_mode_err}, 0);
                if (have_last)
                    check(out_chan == last_chan, "R9 held channel", out_chan, last_chan);
            end
        end
    end

    initial begin
        #400000;
        $display("FAIL watchdog expired actual=0 expected=1");
        n_checks++; n_fail++;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0 && !out_range_err && !out_mode_err, "R1 reset state",
              out_valid, 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        idle(2);
        // R3 straight
        drive(2'd0, 5'd3, 15'h7FFF, 4'hF);
        drive(2'd0, 5'd15, 15'h0, 4'h0);
        drive(2'd0, 5'd16, 15'h1234, 4'h1);   // R7 boundary
        drive(2'd0, 5'd31, 15'h0, 4'h0);
        idle(2);
        // R4 row XOR
        drive(2'd1, 5'd3, 15'h2BCD, 4'h0);
        drive(2'd1, 5'd0, 15'h000F, 4'h5);
        drive(2'd1, 5'd17, 15'h0001, 4'h0);   // R7 stays out of range
        drive(2'd1, 5'd12, 15'h7FF0, 4'h0);
        idle(1);
        // R5 entropy: single row and bank bits, then mixtures
        for (int i = 0; i < RW; i++) drive(2'd2, 5'd0, RW'(1) << i, 4'h0);
        for (int i = 0; i < BW; i++) drive(2'd2, 5'd0, 15'h0, BW'(1) << i);
        for (int i = 0; i < 40; i++)
            drive(2'd2, CW'(i * 11), RW'(i * 16'h3A7 + 5), BW'(i * 3));
        idle(3);
        // R6 reserved
        drive(2'd3, 5'd9, 15'h7FFF, 4'hF);
        drive(2'd3, 5'd20, 15'h0, 4'h0);
        idle(1);
        drive(2'd0, 5'd1, 15'h0, 4'h0);
        idle(3);
        @(negedge clk);
        check(expq.size() == 0, "R2 all results delivered", expq.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule